// File: doc/BRIEF.md
# Host Serial Byte Port with Address Marker

This block is the byte link between a host processor and a network link controller. On the host side it speaks serial frames. On the controller side it offers a transmit byte handshake and a receive byte strobe. Every byte carries a flag that says whether it is an address or data. Three static select inputs choose the framing:
- UART or clocked-serial operation.
- With or without a ninth marker bit that carries the address/data flag.
- In UART operation only, with or without a parity bit.

In clocked-serial operation the host supplies the bit clock. The port samples the incoming line on each rising clock edge and moves its outgoing line on the falling edge. There is no parity in this operation. In UART operation the port makes its own timing from a parameterised divider that runs at sixteen ticks per bit. The receiver confirms a start bit at mid-bit and then samples each later bit at its centre. It flags a parity mismatch and a low stop bit with each received byte.

Top module: `hsp_port`

## Requirements
- R1: Bytes are sent and received least significant bit first, in both UART and clocked operation.
- R2: A UART frame sent by the port is a low start bit, 8 data bits, the optional marker, the optional parity bit and a high stop bit, for a total of 10, 11 or 12 bits.
- R3: When cfg_mark is 1, the marker bit follows bit 7 and equals tx_addr (1 = address, 0 = data), and a received marker appears on rx_addr. When cfg_mark is 0, no marker is sent, tx_addr has no effect and rx_addr reads 0.
- R4: With cfg_parity = 1 in UART operation, a parity bit follows the data bits and the marker. It makes the number of ones over data, marker and parity even. With cfg_parity = 0, no parity bit is present.
- R5: A received UART frame whose data, marker and parity hold an odd number of ones sets rx_perr with that byte. rx_perr stays 0 when parity is disabled.
- R6: A received UART frame whose stop bit is sampled low sets rx_ferr with that byte.
- R7: A low pulse on ser_rx that has ended before the middle of the start bit produces no byte.
- R8: In UART operation one bit lasts 16 ticks of a divider that ticks every DIV clocks, so a bit is 16*DIV clocks long.
- R9: With cfg_uart = 0, the port samples ser_rx on rising ser_sclk edges and changes ser_tx only on falling edges. A frame is 8 bits, or 9 bits with the marker, and cfg_parity has no effect.
- R10: A byte is taken on a clock edge where tx_valid and tx_ready are both 1. tx_ready stays 0 until the whole frame has left the port.
- R11: rx_valid is a single-cycle pulse for each received frame, with rx_byte, rx_addr, rx_perr and rx_ferr valid in that cycle.
- R12: After reset, and whenever no frame is being sent, ser_tx is 1, tx_ready is 1 and rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_uart | input | 1 | 1 = UART operation, 0 = clocked serial operation |
| cfg_mark | input | 1 | 1 = add the address/data marker bit |
| cfg_parity | input | 1 | 1 = even parity bit in UART operation |
| ser_sclk | input | 1 | Bit clock from the host in clocked operation |
| ser_rx | input | 1 | Serial data from the host |
| ser_tx | output | 1 | Serial data to the host, idles high |
| tx_valid | input | 1 | Byte to send is offered |
| tx_byte | input | 8 | Byte to send |
| tx_addr | input | 1 | Address flag of the byte to send |
| tx_ready | output | 1 | Port can take a byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| rx_addr | output | 1 | Received address flag |
| rx_perr | output | 1 | Parity error on received byte |
| rx_ferr | output | 1 | Framing (low stop) error on received byte |

## Verification
The hardest behaviours to reach from the ports are the error paths of the UART receiver. These are a start pulse that vanishes before mid-bit, a corrupted parity bit and a stop bit held low. A correct host never produces any of them. The bench therefore builds receive frames bit by bit on ser_rx, where it can invert the parity bit, hold the stop bit low, or cut a start bit after a few clocks. After each fault it sends a clean frame, which shows that the receiver has returned to its idle state.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    localparam int DW  = 8;
    localparam int OVS = 16;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } urx_state_e;
endpackage

// File: rtl/hsp_baud.sv
module hsp_baud #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_pass
            // every clock is an oversample tick
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_d, cnt_q;
            always_comb begin
                cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
            assign tick = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/hsp_uart_tx.sv
module hsp_uart_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       mark_en,
    input  logic       par_en,
    input  logic       ld_valid,
    input  logic [7:0] ld_byte,
    input  logic       ld_addr,
    output logic       ld_ready,
    output logic       txd
);
    typedef struct packed {
        logic        busy;
        logic [11:0] sh;
        logic [3:0]  left;
        logic [3:0]  ocnt;
    } utx_s;

    utx_s q, d;
    logic take;
    logic pbit;

    always_comb begin
        d    = q;
        take = en && !q.busy && ld_valid;
        pbit = (^ld_byte) ^ (mark_en & ld_addr);
        if (take) begin
            d.busy      = 1'b1;
            d.ocnt      = '0;
            d.sh        = '1;
            d.sh[0]     = 1'b0;
            d.sh[8:1]   = ld_byte;
            if (mark_en) begin
                d.sh[9] = ld_addr;
                if (par_en) d.sh[10] = pbit;
            end else if (par_en) begin
                d.sh[9] = pbit;
            end
            d.left = 4'd10 + {3'b0, mark_en} + {3'b0, par_en};
        end else if (q.busy && tick) begin
            d.ocnt = q.ocnt + 1'b1;
            if (q.ocnt == 4'd15) begin
                d.sh   = {1'b1, q.sh[11:1]};
                d.left = q.left - 1'b1;
                if (q.left == 4'd1) d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sh: '1, left: '0, ocnt: '0};
        else        q <= d;
    end

    assign ld_ready = en && !q.busy;
    assign txd      = q.busy ? q.sh[0] : 1'b1;

    // R2: a taken byte puts the start bit on the line at once
    a_r2_start_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> (txd == 1'b0));
    // R10: no second byte is offered space right after a take
    a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> !ld_ready);
    // R8: the line only moves at the end of a 16-tick bit
    a_r8_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && en && !(tick && q.ocnt == 4'd15)) |=> $stable(txd));
endmodule

// File: rtl/hsp_uart_rx.sv
module hsp_uart_rx
    import hsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       mark_en,
    input  logic       par_en,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       rx_addr,
    output logic       rx_perr,
    output logic       rx_ferr
);
    typedef struct packed {
        urx_state_e  st;
        logic [3:0]  ocnt;
        logic [3:0]  idx;
        logic [9:0]  sh;
        logic        hi;
        logic        valid;
        logic [7:0]  byte_v;
        logic        addr;
        logic        perr;
        logic        ferr;
    } urx_s;

    urx_s q, d;
    logic [3:0] nb;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        nb      = 4'd8 + {3'b0, mark_en} + {3'b0, par_en};
        if (!en) begin
            d.st = RX_IDLE;
            d.hi = 1'b0;
        end else if (tick) begin
            case (q.st)
                RX_IDLE: begin
                    if (rxd) begin
                        d.hi = 1'b1;
                    end else if (q.hi) begin
                        d.st   = RX_START;
                        d.ocnt = '0;
                    end
                end
                RX_START: begin
                    d.ocnt = q.ocnt + 1'b1;
                    if (q.ocnt == 4'd7) begin
                        if (!rxd) begin
                            d.st   = RX_BITS;
                            d.ocnt = '0;
                            d.idx  = '0;
                            d.sh   = '0;
                        end else begin
                            d.st = RX_IDLE;
                            d.hi = 1'b0;
                        end
                    end
                end
                RX_BITS: begin
                    d.ocnt = q.ocnt + 1'b1;
                    if (q.ocnt == 4'd15) begin
                        if (q.idx == nb) begin
                            d.valid  = 1'b1;
                            d.byte_v = q.sh[7:0];
                            d.addr   = mark_en & q.sh[8];
                            d.perr   = par_en & (^q.sh);
                            d.ferr   = !rxd;
                            d.st     = RX_IDLE;
                            d.hi     = 1'b0;
                        end else begin
                            d.sh[q.idx] = rxd;
                            d.idx       = q.idx + 1'b1;
                        end
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, ocnt: '0, idx: '0, sh: '0, hi: 1'b0,
                           valid: 1'b0, byte_v: '0, addr: 1'b0, perr: 1'b0, ferr: 1'b0};
        else        q <= d;
    end

    assign rx_valid = q.valid;
    assign rx_byte  = q.byte_v;
    assign rx_addr  = q.addr;
    assign rx_perr  = q.perr;
    assign rx_ferr  = q.ferr;

    // R11: each received frame gives a single-cycle strobe
    a_r11_uart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R7: a start bit high again at mid-bit returns to idle with no byte
    a_r7_glitch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && q.st == RX_START && q.ocnt == 4'd7 && rxd) |=> (q.st == RX_IDLE && !rx_valid));
    // R5: without parity no parity error is ever reported
    a_r5_no_perr_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(par_en)) |-> !rx_perr);
endmodule

// File: rtl/hsp_sync.sv
module hsp_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       mark_en,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       sdi,
    input  logic       ld_valid,
    input  logic [7:0] ld_byte,
    input  logic       ld_addr,
    output logic       ld_ready,
    output logic       sdo,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       rx_addr
);
    typedef struct packed {
        logic       tbusy;
        logic       armed;
        logic [8:0] tsh;
        logic [3:0] tcnt;
        logic [8:0] rsh;
        logic [3:0] rcnt;
        logic       valid;
        logic [7:0] byte_v;
        logic       addr;
    } sync_s;

    sync_s q, d;
    logic [3:0] last;
    logic [8:0] rtmp;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        last    = mark_en ? 4'd8 : 4'd7;
        rtmp    = q.rsh;
        rtmp[q.rcnt] = sdi;
        if (!en) begin
            d.tbusy = 1'b0;
            d.armed = 1'b0;
            d.rcnt  = '0;
        end else begin
            if (!q.tbusy && ld_valid) begin
                d.tbusy = 1'b1;
                d.armed = 1'b0;
                d.tcnt  = '0;
                d.tsh   = {mark_en & ld_addr, ld_byte};
            end else if (q.tbusy) begin
                if (sclk_rise) begin
                    d.armed = 1'b1;
                end else if (sclk_fall && q.armed) begin
                    d.armed = 1'b0;
                    d.tsh   = {1'b1, q.tsh[8:1]};
                    d.tcnt  = q.tcnt + 1'b1;
                    if (q.tcnt == last) d.tbusy = 1'b0;
                end
            end
            if (sclk_rise) begin
                d.rsh = rtmp;
                if (q.rcnt == last) begin
                    d.rcnt   = '0;
                    d.valid  = 1'b1;
                    d.byte_v = rtmp[7:0];
                    d.addr   = mark_en & rtmp[8];
                end else begin
                    d.rcnt = q.rcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tbusy: 1'b0, armed: 1'b0, tsh: '1, tcnt: '0, rsh: '0,
                           rcnt: '0, valid: 1'b0, byte_v: '0, addr: 1'b0};
        else        q <= d;
    end

    assign ld_ready = en && !q.tbusy;
    assign sdo      = q.tbusy ? q.tsh[0] : 1'b1;
    assign rx_valid = q.valid;
    assign rx_byte  = q.byte_v;
    assign rx_addr  = q.addr;

    // R9: the outgoing line moves only on a falling bit-clock edge
    a_r9_move_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.tbusy && !sclk_fall) |=> $stable(sdo));
    // R3: without the marker no address flag is reported
    a_r3_plain_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(mark_en)) |-> !rx_addr);
    // R11: one strobe per clocked frame
    a_r11_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/hsp_port.sv
module hsp_port #(
    parameter int DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_uart,
    input  logic       cfg_mark,
    input  logic       cfg_parity,
    input  logic       ser_sclk,
    input  logic       ser_rx,
    output logic       ser_tx,
    input  logic       tx_valid,
    input  logic [7:0] tx_byte,
    input  logic       tx_addr,
    output logic       tx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       rx_addr,
    output logic       rx_perr,
    output logic       rx_ferr
);
    typedef struct packed {
        logic rx1;
        logic rx2;
        logic ck1;
        logic ck2;
        logic ck3;
    } pin_s;

    pin_s q, d;
    logic tick;
    logic rise, fall;
    logic u_ready, u_txd, u_valid, u_addr, u_perr, u_ferr;
    logic s_ready, s_txd, s_valid, s_addr;
    logic [7:0] u_byte, s_byte;

    always_comb begin
        d     = q;
        d.rx1 = ser_rx;
        d.rx2 = q.rx1;
        d.ck1 = ser_sclk;
        d.ck2 = q.ck1;
        d.ck3 = q.ck2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{rx1: 1'b1, rx2: 1'b1, ck1: 1'b0, ck2: 1'b0, ck3: 1'b0};
        else        q <= d;
    end

    assign rise = q.ck2 & ~q.ck3;
    assign fall = ~q.ck2 & q.ck3;

    hsp_baud #(.DIV(DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    hsp_uart_tx u_utx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg_uart),
        .mark_en(cfg_mark), .par_en(cfg_parity),
        .ld_valid(tx_valid), .ld_byte(tx_byte), .ld_addr(tx_addr),
        .ld_ready(u_ready), .txd(u_txd)
    );

    hsp_uart_rx u_urx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg_uart),
        .mark_en(cfg_mark), .par_en(cfg_parity), .rxd(q.rx2),
        .rx_valid(u_valid), .rx_byte(u_byte), .rx_addr(u_addr),
        .rx_perr(u_perr), .rx_ferr(u_ferr)
    );

    hsp_sync u_sync (
        .clk(clk), .rst_n(rst_n), .en(!cfg_uart), .mark_en(cfg_mark),
        .sclk_rise(rise), .sclk_fall(fall), .sdi(q.rx2),
        .ld_valid(tx_valid), .ld_byte(tx_byte), .ld_addr(tx_addr),
        .ld_ready(s_ready), .sdo(s_txd),
        .rx_valid(s_valid), .rx_byte(s_byte), .rx_addr(s_addr)
    );

    assign ser_tx   = cfg_uart ? u_txd   : s_txd;
    assign tx_ready = cfg_uart ? u_ready : s_ready;
    assign rx_valid = u_valid | s_valid;
    assign rx_byte  = cfg_uart ? u_byte  : s_byte;
    assign rx_addr  = cfg_uart ? u_addr  : s_addr;
    assign rx_perr  = cfg_uart & u_perr;
    assign rx_ferr  = cfg_uart & u_ferr;

    // R11: only one receive path ever strobes in a cycle
    a_r11_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({u_valid, s_valid}));
endmodule

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;
    localparam int H   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_uart = 1'b1, cfg_mark = 1'b0, cfg_parity = 1'b0;
    logic ser_sclk = 1'b0, ser_rx = 1'b1;
    logic ser_tx;
    logic tx_valid = 1'b0;
    logic [7:0] tx_byte = '0;
    logic tx_addr = 1'b0;
    logic tx_ready, rx_valid, rx_addr, rx_perr, rx_ferr;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0;
    int got_n = 0;
    logic [7:0] got_byte;
    logic got_addr, got_perr, got_ferr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hsp_port #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_uart(cfg_uart), .cfg_mark(cfg_mark),
        .cfg_parity(cfg_parity), .ser_sclk(ser_sclk), .ser_rx(ser_rx), .ser_tx(ser_tx),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_addr(tx_addr), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_addr(rx_addr),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got_n    <= got_n + 1;
            got_byte <= rx_byte;
            got_addr <= rx_addr;
            got_perr <= rx_perr;
            got_ferr <= rx_ferr;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // expected UART frame, LSB first: start, data, marker, parity, stop
    function automatic logic [11:0] uframe(input logic [7:0] b, input logic a,
                                           input logic badp, input logic bads);
        logic [11:0] f;
        logic p;
        f = '1;
        f[0] = 1'b0;
        f[8:1] = b;
        p = (^b) ^ (cfg_mark & a) ^ badp;
        if (cfg_mark) begin
            f[9] = a;
            if (cfg_parity) f[10] = p;
        end else if (cfg_parity) begin
            f[9] = p;
        end
        f[9 + int'(cfg_mark) + int'(cfg_parity)] = ~bads;
        return f;
    endfunction

    task automatic load_tx(input logic [7:0] b, input logic a);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_byte  = b;
        tx_addr  = a;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic uart_tx_check(input logic [7:0] b, input logic a);
        logic [11:0] e, act;
        int len;
        int guard;
        e   = uframe(b, a, 1'b0, 1'b0);
        len = 10 + int'(cfg_mark) + int'(cfg_parity);
        act = '1;
        load_tx(b, a);
        guard = 0;
        while (ser_tx && guard < 4 * BIT) begin
            @(negedge clk);
            guard++;
        end
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            act[i] = ser_tx;
            if (i == 1) chk(tx_ready == 1'b0, "R10 ready low mid-frame", tx_ready, 0);
            repeat (BIT) @(negedge clk);
        end
        chk((act ^ e) == 12'h000, "R1 R2 R3 R4 uart tx frame", act, e);
        chk(ser_tx == 1'b1 && tx_ready == 1'b1, "R12 R10 idle after frame",
            {ser_tx, tx_ready}, 2'b11);
    endtask

    task automatic uart_rx_send(input logic [7:0] b, input logic a,
                                input logic badp, input logic bads);
        logic [11:0] f;
        int len, prev;
        f    = uframe(b, a, badp, bads);
        len  = 10 + int'(cfg_mark) + int'(cfg_parity);
        prev = got_n;
        for (int i = 0; i < len; i++) begin
            ser_rx = f[i];
            repeat (BIT) @(negedge clk);
        end
        ser_rx = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk(got_n == prev + 1, "R11 one strobe per frame", got_n - prev, 1);
        chk(got_byte == b, "R1 uart rx byte", got_byte, b);
        chk(got_addr == (cfg_mark & a), "R3 uart rx marker", got_addr, cfg_mark & a);
        chk(got_perr == (cfg_parity & badp), "R5 parity error flag", got_perr, cfg_parity & badp);
        chk(got_ferr == bads, "R6 framing error flag", got_ferr, bads);
    endtask

    task automatic sync_xfer(input logic [7:0] db, input logic da,
                             input logic [7:0] hb, input logic ha);
        logic [8:0] e, act, h;
        int nb, prev;
        nb   = 8 + int'(cfg_mark);
        e    = {cfg_mark & da, db};
        h    = {ha, hb};
        act  = '0;
        prev = got_n;
        load_tx(db, da);
        for (int i = 0; i < nb; i++) begin
            ser_rx = h[i];
            repeat (H) @(negedge clk);
            act[i] = ser_tx;
            ser_sclk = 1'b1;
            repeat (H) @(negedge clk);
            ser_sclk = 1'b0;
        end
        repeat (H + 4) @(negedge clk);
        if (!cfg_mark) begin
            act[8] = 1'b0;
            e[8] = 1'b0;
        end
        chk(act == e, "R9 R1 clocked tx bits", act, e);
        chk(got_n == prev + 1, "R9 R11 clocked frame strobe", got_n - prev, 1);
        chk(got_byte == hb, "R9 R1 clocked rx byte", got_byte, hb);
        chk(got_addr == (cfg_mark & ha), "R3 clocked rx marker", got_addr, cfg_mark & ha);
        chk(tx_ready == 1'b1 && ser_tx == 1'b1, "R10 R12 clocked idle", {tx_ready, ser_tx}, 2'b11);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R12 actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_tx == 1'b1 && tx_ready == 1'b1 && rx_valid == 1'b0, "R12 reset state",
            {ser_tx, tx_ready, rx_valid}, 3'b110);

        // R8: start bit of 0xFF lasts one bit time
        begin
            int len;
            load_tx(8'hFF, 1'b0);
            len = 1;
            while (!ser_tx && len < 4 * BIT) begin
                @(negedge clk);
                len++;
            end
            chk(len >= BIT - 2 && len <= BIT + 1, "R8 bit length", len, BIT);
            repeat (12 * BIT) @(negedge clk);
        end

        for (int cfg = 0; cfg < 4; cfg++) begin
            cfg_mark   = cfg[0];
            cfg_parity = cfg[1];
            for (int k = 0; k < 24; k++) begin
                logic [7:0] b;
                logic a;
                b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 73 + cfg * 29) & 255);
                a = k[0];
                uart_tx_check(b, a);
                uart_rx_send(b ^ 8'h5A, ~a, 1'b0, 1'b0);
            end
        end

        // error paths
        cfg_mark = 1'b1; cfg_parity = 1'b1;
        uart_rx_send(8'h3C, 1'b1, 1'b1, 1'b0);   // R5
        uart_rx_send(8'h3C, 1'b1, 1'b0, 1'b1);   // R6
        uart_rx_send(8'hC3, 1'b0, 1'b0, 1'b0);
        cfg_parity = 1'b0;
        uart_rx_send(8'h81, 1'b0, 1'b1, 1'b0);   // R5 flag stays 0 without parity

        // R7 short start pulse
        begin
            int prev;
            prev = got_n;
            ser_rx = 1'b0;
            repeat (6) @(negedge clk);
            ser_rx = 1'b1;
            repeat (3 * BIT) @(negedge clk);
            chk(got_n == prev, "R7 short start ignored", got_n - prev, 0);
        end
        uart_rx_send(8'hA5, 1'b1, 1'b0, 1'b0);

        // clocked serial operation
        cfg_uart = 1'b0;
        repeat (4) @(negedge clk);
        for (int cfg = 0; cfg < 2; cfg++) begin
            cfg_mark = cfg[0];
            for (int k = 0; k < 16; k++) begin
                logic [7:0] b;
                b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 151 + cfg * 7) & 255);
                sync_xfer(b, k[0], ~b, ~k[0]);
            end
        end
        cfg_mark = 1'b0; cfg_parity = 1'b1;   // R9 parity select has no effect
        sync_xfer(8'h96, 1'b1, 8'h2D, 1'b1);
        sync_xfer(8'h01, 1'b0, 8'h80, 1'b0);

        summary();
        $finish;
    end
endmodule